// File: doc/BRIEF.md
# Banked Data Pointer Register Unit

This unit keeps two physical 16-bit data pointers for an 8-bit microcontroller core and presents them to the core as a single logical pointer. A select bit in an auxiliary control register picks which physical pointer is visible. Software can hold a source address in one pointer and a destination address in the other, and switch between them with one short register update instead of saving and restoring a pointer.

The core reaches the unit in two ways. A byte-wide special-register port reads and writes the high byte and low byte of the visible pointer, and also the auxiliary control register. Pointer commands load all 16 bits at once or increment the visible pointer. The unit always drives the visible pointer for external data and code addressing. It also drives an indexed address, which is that pointer plus an 8-bit accumulator value.

The select bit is a two-state machine. State SEL_P0 shows pointer 0 and state SEL_P1 shows pointer 1. Reset enters SEL_P0. The transition TO_P0 is taken on a control-register write with bit 0 clear, and TO_P1 on such a write with bit 0 set. With no control-register write, the unit stays in its current state (HOLD). The control register also stores a wake-up enable flag, which the unit passes out unchanged for logic outside this block.

Top module: `dual_ptr_unit`

## Requirements
- R1: After reset both pointers are 0x0000, the state is SEL_P0, the wake-up enable is 0, and a read of the control register (address 0xA2) returns 0xF2.
- R2: A byte write to address 0x83 replaces the high byte of the selected pointer, and a byte write to 0x82 replaces its low byte. The other pointer is not affected. Reads of 0x83 and 0x82 return the bytes of the selected pointer.
- R3: A write to 0xA2 sets the select bit from data bit 0 (0 selects pointer 0, 1 selects pointer 1). From the next cycle, cur_ptr shows the selected pointer.
- R4: A read of 0xA2 returns bits 7:4 and bit 1 as 1, bit 2 as 0 whatever was written, bit 3 as the wake-up enable and bit 0 as the select bit. A write to 0xA2 stores data bit 3 as the wake-up enable.
- R5: Reading 0xA2, adding one and writing the sum back toggles the select bit and leaves the wake-up enable unchanged.
- R6: ptr_load writes ptr_imm into the selected pointer in one cycle. The other pointer is unchanged.
- R7: ptr_inc adds one to the selected 16-bit pointer, with carry from the low byte into the high byte, and wraps from 0xFFFF to 0x0000. The other pointer is unchanged.
- R8: idx_addr equals the selected pointer plus the zero-extended acc, taken modulo 2^16. It changes no pointer.
- R9: When a pointer command and a byte write to the selected pointer occur in the same cycle, the command wins. When load and increment occur together, load wins.
- R10: The read port returns the value stored before the current cycle's update. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Special-register byte address |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_rdata | output | 8 | Byte read data for sfr_addr |
| ptr_load | input | 1 | Load ptr_imm into the selected pointer |
| ptr_imm | input | 16 | Immediate pointer value |
| ptr_inc | input | 1 | Increment the selected pointer |
| acc | input | 8 | Accumulator value for the indexed address |
| cur_ptr | output | 16 | Selected pointer |
| idx_addr | output | 16 | Selected pointer plus acc |
| wake_en | output | 1 | Stored wake-up enable |

## Verification
The bench builds the unit with its default parameters: a 16-bit pointer, an 8-bit accumulator and the register addresses 0x83, 0x82 and 0xA2. With a 16-bit width, one load of 0xFFFF reaches the wrap boundary and one load of 0x00FF reaches the carry from low byte to high byte. Random byte accesses spread over the four address classes, random commands and random accumulator values exercise both banks, the SEL_P0 and SEL_P1 states, and collisions between a command and a byte write.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
    localparam int BYTE_W  = 8;
    localparam int NUM_PTR = 2;

    typedef enum logic {
        SEL_P0 = 1'b0,
        SEL_P1 = 1'b1
    } sel_state_t;
endpackage

// File: rtl/dptr_bank.sv
module dptr_bank
    import dptr_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_me,
    input  logic              ld,
    input  logic              inc,
    input  logic [PTR_W-1:0]  imm,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  value
);
    localparam int HI_LSB = PTR_W - BYTE_W;

    logic [PTR_W-1:0] nxt;

    always_comb begin
        nxt = value;
        if (sel_me && ld) begin
            nxt = imm;
        end else if (sel_me && inc) begin
            nxt = value + {{(PTR_W-1){1'b0}}, 1'b1};
        end else begin
            if (wr_hi) nxt[PTR_W-1:HI_LSB] = wdata;
            if (wr_lo) nxt[BYTE_W-1:0]     = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= nxt;
    end

    // R6
    load_takes_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_me && ld) |=> (value == $past(imm)));

    // R7
    inc_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_me && inc && !ld) |=> (value == $past(value) + 1'b1));

    // R2
    idle_bank_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_me && !wr_hi && !wr_lo) |=> $stable(value));
endmodule

// File: rtl/dptr_ctl.sv
module dptr_ctl
    import dptr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic              sel,
    output logic              wake,
    output logic [BYTE_W-1:0] ctl_rd
);
    sel_state_t state, state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEL_P0: if (ctl_wr && wdata[0])  state_nxt = SEL_P1;
            SEL_P1: if (ctl_wr && !wdata[0]) state_nxt = SEL_P0;
            default: state_nxt = SEL_P0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEL_P0;
            wake  <= 1'b0;
        end else begin
            state <= state_nxt;
            if (ctl_wr) wake <= wdata[3];
        end
    end

    always_comb begin
        unique case (state)
            SEL_P0:  sel = 1'b0;
            SEL_P1:  sel = 1'b1;
            default: sel = 1'b0;
        endcase
        ctl_rd = {4'hF, wake, 1'b0, 1'b1, sel};
    end

    // R3
    select_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (sel == $past(wdata[0])));

    // R5
    wake_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable(wake));
endmodule

// File: rtl/dptr_index.sv
module dptr_index #(
    parameter int PTR_W = 16,
    parameter int ACC_W = 8
) (
    input  logic [PTR_W-1:0] base,
    input  logic [ACC_W-1:0] ofs,
    output logic [PTR_W-1:0] sum
);
    always_comb sum = base + {{(PTR_W-ACC_W){1'b0}}, ofs};
endmodule

// File: rtl/dual_ptr_unit.sv
module dual_ptr_unit
    import dptr_pkg::*;
#(
    parameter int          PTR_W   = 16,
    parameter int          ACC_W   = 8,
    parameter logic [7:0]  HI_ADR  = 8'h83,
    parameter logic [7:0]  LO_ADR  = 8'h82,
    parameter logic [7:0]  CTL_ADR = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_imm,
    input  logic              ptr_inc,
    input  logic [ACC_W-1:0]  acc,
    output logic [PTR_W-1:0]  cur_ptr,
    output logic [PTR_W-1:0]  idx_addr,
    output logic              wake_en
);
    localparam int HI_LSB = PTR_W - BYTE_W;

    logic              sel;
    logic [BYTE_W-1:0] ctl_rd;
    logic [PTR_W-1:0]  bank_val [NUM_PTR];
    logic              hit_hi, hit_lo, hit_ctl;

    always_comb begin
        hit_hi  = (sfr_addr == HI_ADR);
        hit_lo  = (sfr_addr == LO_ADR);
        hit_ctl = (sfr_addr == CTL_ADR);
    end

    dptr_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl_wr (sfr_wr && hit_ctl),
        .wdata  (sfr_wdata),
        .sel    (sel),
        .wake   (wake_en),
        .ctl_rd (ctl_rd)
    );

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_bank
        logic mine;
        always_comb mine = (sel == g[0]);
        dptr_bank #(.PTR_W(PTR_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .sel_me(mine),
            .ld    (ptr_load),
            .inc   (ptr_inc),
            .imm   (ptr_imm),
            .wr_hi (mine && sfr_wr && hit_hi),
            .wr_lo (mine && sfr_wr && hit_lo),
            .wdata (sfr_wdata),
            .value (bank_val[g])
        );
    end

    always_comb cur_ptr = sel ? bank_val[1] : bank_val[0];

    dptr_index #(.PTR_W(PTR_W), .ACC_W(ACC_W)) u_idx (
        .base (cur_ptr),
        .ofs  (acc),
        .sum  (idx_addr)
    );

    always_comb begin
        if (hit_hi)       sfr_rdata = cur_ptr[PTR_W-1:HI_LSB];
        else if (hit_lo)  sfr_rdata = cur_ptr[BYTE_W-1:0];
        else if (hit_ctl) sfr_rdata = ctl_rd;
        else              sfr_rdata = '0;
    end

    // R8
    index_no_side_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_load && !ptr_inc && !sfr_wr) |=> $stable(cur_ptr));

    // R4
    guard_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctl |-> (sfr_rdata[2] == 1'b0 && sfr_rdata[1] == 1'b1));
endmodule

// File: tb/dual_ptr_unit_test.sv
module dual_ptr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        ptr_load = 1'b0;
    logic [15:0] ptr_imm = 16'h0000;
    logic        ptr_inc = 1'b0;
    logic [7:0]  acc = 8'h00;
    logic [15:0] cur_ptr;
    logic [15:0] idx_addr;
    logic        wake_en;

    int checks = 0;
    int errors = 0;

    logic [15:0] mp [2];
    logic        msel;
    logic        mwake;

    always #4 clk = ~clk;

    dual_ptr_unit uut (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ptr_load(ptr_load),
        .ptr_imm(ptr_imm), .ptr_inc(ptr_inc), .acc(acc), .cur_ptr(cur_ptr),
        .idx_addr(idx_addr), .wake_en(wake_en)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h83)      return mp[msel][15:8];
        else if (a == 8'h82) return mp[msel][7:0];
        else if (a == 8'hA2) return {4'hF, mwake, 1'b0, 1'b1, msel};
        else                 return 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d,
                        input logic l, input logic [15:0] im, input logic i,
                        input logic [7:0] ac, input string tag);
        @(negedge clk);
        sfr_addr = a; sfr_wr = w; sfr_wdata = d;
        ptr_load = l; ptr_imm = im; ptr_inc = i; acc = ac;
        #1;
        chk({tag, " rdata R10"}, {8'h00, sfr_rdata}, {8'h00, exp_read(a)});
        chk({tag, " cur_ptr R3"}, cur_ptr, mp[msel]);
        chk({tag, " idx_addr R8"}, idx_addr, mp[msel] + {8'h00, ac});
        chk({tag, " wake_en R4"}, {15'h0, wake_en}, {15'h0, mwake});
        @(posedge clk);
        if (l)      mp[msel] = im;
        else if (i) mp[msel] = mp[msel] + 16'h0001;
        else if (w && a == 8'h83) mp[msel][15:8] = d;
        else if (w && a == 8'h82) mp[msel][7:0]  = d;
        if (w && a == 8'hA2) begin
            msel  = d[0];
            mwake = d[3];
        end
        #1;
        sfr_wr = 1'b0; ptr_load = 1'b0; ptr_inc = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        mp[0] = 16'h0; mp[1] = 16'h0; msel = 1'b0; mwake = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        step(8'hA2, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R1 reset");
        chk("R1 aux read", {8'h00, sfr_rdata}, 16'h00F2);
        step(8'h83, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R1 ptr0");

        // R6: load pointer 0, switch, load pointer 1, switch back
        step(8'h00, 0, 8'h00, 1, 16'h1234, 0, 8'h00, "R6 load p0");
        step(8'hA2, 1, 8'h01, 0, 16'h0, 0, 8'h00, "R3 select p1");
        step(8'h83, 0, 8'h00, 1, 16'hBEEF, 0, 8'h10, "R6 p1 starts zero");
        step(8'hA2, 1, 8'h00, 0, 16'h0, 0, 8'h00, "R3 select p0");
        step(8'h83, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R6 p0 kept hi");
        chk("R6 p0 hi byte", {8'h00, sfr_rdata}, 16'h0012);

        // R2: byte writes reach selected pointer only
        step(8'h82, 1, 8'h77, 0, 16'h0, 0, 8'h00, "R2 write lo");
        step(8'h82, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R2 read lo");
        chk("R2 lo byte", {8'h00, sfr_rdata}, 16'h0077);

        // R4: guard bit ignores writes, undefined bits read 1
        step(8'hA2, 1, 8'h0C, 0, 16'h0, 0, 8'h00, "R4 write guard");
        step(8'hA2, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R4 read");
        chk("R4 aux value", {8'h00, sfr_rdata}, 16'h00FA);

        // R5: read, add one, write back toggles select, keeps wake
        for (int k = 0; k < 4; k++) begin
            step(8'hA2, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R5 read");
            r = sfr_rdata;
            step(8'hA2, 1, r + 8'h01, 0, 16'h0, 0, 8'h00, "R5 write back");
            chk("R5 select toggled", {15'h0, cur_ptr == mp[~r[0]]}, 16'h0001);
            chk("R5 wake kept", {15'h0, wake_en}, 16'h0001);
        end

        // R7: carry and wrap
        step(8'h00, 0, 8'h00, 1, 16'h00FF, 0, 8'h00, "R7 load 00ff");
        step(8'h00, 0, 8'h00, 0, 16'h0, 1, 8'h00, "R7 carry");
        chk("R7 carry value", cur_ptr, 16'h0100);
        step(8'h00, 0, 8'h00, 1, 16'hFFFF, 0, 8'h00, "R7 load ffff");
        step(8'h00, 0, 8'h00, 0, 16'h0, 1, 8'hFF, "R8 idx wraps");
        chk("R7 wrap value", cur_ptr, 16'h0000);

        // R9: command beats byte write; load beats increment
        step(8'h83, 1, 8'h55, 1, 16'hA5A5, 0, 8'h00, "R9 load vs write");
        chk("R9 load wins", cur_ptr, 16'hA5A5);
        step(8'h82, 1, 8'h00, 0, 16'h0, 1, 8'h00, "R9 inc vs write");
        chk("R9 inc wins", cur_ptr, 16'hA5A6);
        step(8'h00, 0, 8'h00, 1, 16'h4000, 1, 8'h00, "R9 load vs inc");
        chk("R9 load over inc", cur_ptr, 16'h4000);

        // R10: unmapped reads
        step(8'h81, 1, 8'h99, 0, 16'h0, 0, 8'h00, "R10 unmapped");
        step(8'h81, 0, 8'h00, 0, 16'h0, 0, 8'h00, "R10 unmapped read");
        chk("R10 unmapped zero", {8'h00, sfr_rdata}, 16'h0000);

        // Random mix against the model
        void'($urandom(32'd20240517));
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a;
            int pick;
            pick = $urandom_range(0, 3);
            a = (pick == 0) ? 8'h83 : (pick == 1) ? 8'h82 :
                (pick == 2) ? 8'hA2 : 8'($urandom_range(0, 255));
            step(a, ($urandom_range(0, 2) == 0), 8'($urandom),
                 ($urandom_range(0, 5) == 0), 16'($urandom),
                 ($urandom_range(0, 3) == 0), 8'($urandom), "R2 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule